// File: doc/BRIEF.md
# Literal-Operand Instruction Execute Unit

This block executes the immediate-operand group of an 8-bit accumulator machine. Each cycle in which `instrValid` is high it decodes one 16-bit instruction word. The low byte of the word is an 8-bit literal. Depending on the opcode, the block updates one or more of the following:

- the working register;
- a 16-bit product held as a high byte and a low byte;
- a 4-bit bank selector;
- a small set of 12-bit address pointers;
- five status flags: carry, digit carry, zero, overflow and negative.

Every state change becomes visible at the same clock edge that samples the word.

Loading a pointer takes two words. The first word names the pointer and carries the top four literal bits. The block holds that word as pending until a matching second word supplies the low byte. A second word that arrives with nothing pending does nothing. Any other word that arrives while a first word is pending discards it.

Return-with-literal loads the working register and raises a one-cycle return request for the surrounding core. An undecoded word raises a one-cycle illegal-instruction pulse and leaves all state as it was.

Top module: `literal_exec`

## Requirements
- R1: While `rstN` is low, the working register, both product bytes, the bank selector, every pointer and all five flags read zero, and `retReq` and `illegal` are low.
- R2: Upper byte 0x0F adds the literal to the working register and writes the sum there. C is the carry out of bit 7, DC is the carry out of bit 3, OV is two's-complement overflow, Z marks a zero result and N is result bit 7.
- R3: Upper byte 0x08 writes literal minus working register to the working register. C is 1 when literal >= working register (unsigned, so no borrow). DC is 1 when literal[3:0] >= working register[3:0]. OV marks signed overflow of the difference. Z and N follow the result.
- R4: Upper bytes 0x0B (AND), 0x09 (OR) and 0x0A (XOR) combine the literal with the working register and write the result there. Only Z and N are updated; C, DC and OV hold their values.
- R5: Upper byte 0x0E copies the literal into the working register and leaves all flags unchanged.
- R6: Upper byte 0x0D forms the unsigned 8x8 product of the literal and the working register and writes bits 15:8 to `prodHi` and bits 7:0 to `prodLo`. The working register and the flags are unchanged.
- R7: A word whose bits 15:4 equal 0x010 copies bits 3:0 into the bank selector and changes nothing else.
- R8: A first word has bits 15:6 = 1110111000. Bits 5:4 (value 0 to 2) select the pointer and bits 3:0 give pointer bits 11:8; the first word itself changes no visible state. A following second word 0xF0kk writes {bits 11:8, kk} into the selected pointer (pointer n occupies `ptrFlat[12n+11:12n]`). The pending first word is kept across cycles with `instrValid` low.
- R9: A second word 0xF0kk with no pending first word changes no state and does not raise `illegal`.
- R10: Any valid word other than a second word discards a pending first word and then executes as usual. A new first word replaces the pending one.
- R11: Upper byte 0x0C copies the literal into the working register, leaves the flags unchanged, and drives `retReq` high for exactly the cycle after the sampling edge.
- R12: Every other word raises `illegal` for the cycle after the sampling edge and changes no state. This includes upper byte 0x01 with bits 7:4 nonzero, a first word with bits 7:6 nonzero, and a first word with selector 3.
- R13: A cycle with `instrValid` low changes no state, and `retReq` and `illegal` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| instrValid | input | 1 | `instrWord` is to be executed this cycle |
| instrWord | input | 16 | Instruction word |
| wreg | output | 8 | Working register |
| prodHi | output | 8 | High byte of the last product |
| prodLo | output | 8 | Low byte of the last product |
| bankSel | output | 4 | Bank selector |
| ptrFlat | output | NUM_PTR*PTR_W | All pointers; pointer 0 in the low bits |
| flagC | output | 1 | Carry / no-borrow flag |
| flagDc | output | 1 | Digit carry / no-borrow-from-bit-3 flag |
| flagZ | output | 1 | Zero flag |
| flagOv | output | 1 | Signed overflow flag |
| flagN | output | 1 | Negative flag |
| retReq | output | 1 | One-cycle return request |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bench uses the default build: three pointers of 12 bits each. With these values every valid selector can be exercised, and selector 3 falls outside the range, so it must be rejected as illegal.

The 8-bit operand space is small enough to sweep exhaustively. The bench drives every working-register value against a literal set that includes the carry and signed-overflow boundaries, for add and subtract. It covers every working-register value against strided literal sets for the logical operations and for multiply.

Pointer loads are checked for every selector and for several literal patterns. The bench also covers orphaned, abandoned and replaced first words, idle gaps between the two words, and a list of malformed encodings that must be rejected.

// File: rtl/literal_exec_pkg.sv
package literal_exec_pkg;

  localparam int DATA_W = 8;
  localparam int WORD_W = 16;
  localparam int BANK_W = 4;
  localparam int NIB_W  = 4;
  localparam int SEL_W  = 2;

  // Upper-byte opcodes of the literal group
  localparam logic [7:0] OPC_ADD  = 8'h0F;
  localparam logic [7:0] OPC_SUB  = 8'h08;
  localparam logic [7:0] OPC_AND  = 8'h0B;
  localparam logic [7:0] OPC_IOR  = 8'h09;
  localparam logic [7:0] OPC_XOR  = 8'h0A;
  localparam logic [7:0] OPC_MOV  = 8'h0E;
  localparam logic [7:0] OPC_MUL  = 8'h0D;
  localparam logic [7:0] OPC_RET  = 8'h0C;
  localparam logic [7:0] OPC_BANK = 8'h01;
  localparam logic [7:0] OPC_PTR1 = 8'hEE;
  localparam logic [7:0] OPC_PTR2 = 8'hF0;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_IOR  = 3'd4,
    ALU_XOR  = 3'd5
  } alu_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    alu_op_e            aluOp;
    logic               wrWreg;
    logic               wrArith;   // all five flags
    logic               wrLogic;   // Z and N only
    logic               wrProd;
    logic               wrBank;
    logic               wrPtr;
    logic [SEL_W-1:0]   ptrSel;
    logic [NIB_W-1:0]   ptrHi;
  } ctrl_strobe_t;

endpackage

// File: rtl/literal_exec_alu.sv
module literal_exec_alu
  import literal_exec_pkg::*;
(
  input  alu_op_e             aluOp,
  input  logic [DATA_W-1:0]   opW,
  input  logic [DATA_W-1:0]   opK,
  output logic [DATA_W-1:0]   result,
  output logic                carry,
  output logic                halfCarry,
  output logic                ovf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sumFull;
  logic [DATA_W:0] diffFull;
  logic [NIB_W:0]  sumLow;
  logic [NIB_W:0]  diffLow;

  always_comb begin
    sumFull  = {1'b0, opW} + {1'b0, opK};
    // literal minus working register as literal + ~W + 1: top bit is "no borrow"
    diffFull = {1'b0, opK} + {1'b0, ~opW} + (DATA_W+1)'(1);
    sumLow   = {1'b0, opW[NIB_W-1:0]} + {1'b0, opK[NIB_W-1:0]};
    diffLow  = {1'b0, opK[NIB_W-1:0]} + {1'b0, ~opW[NIB_W-1:0]} + (NIB_W+1)'(1);

    result    = opK;
    carry     = 1'b0;
    halfCarry = 1'b0;
    ovf       = 1'b0;
    unique case (aluOp)
      ALU_ADD: begin
        result    = sumFull[MSB:0];
        carry     = sumFull[DATA_W];
        halfCarry = sumLow[NIB_W];
        ovf       = (opW[MSB] == opK[MSB]) && (sumFull[MSB] != opW[MSB]);
      end
      ALU_SUB: begin
        result    = diffFull[MSB:0];
        carry     = diffFull[DATA_W];
        halfCarry = diffLow[NIB_W];
        ovf       = (opK[MSB] != opW[MSB]) && (diffFull[MSB] != opK[MSB]);
      end
      ALU_AND: result = opW & opK;
      ALU_IOR: result = opW | opK;
      ALU_XOR: result = opW ^ opK;
      default: result = opK;
    endcase
  end

endmodule

// File: rtl/literal_exec_ctrl.sv
module literal_exec_ctrl
  import literal_exec_pkg::*;
#(
  parameter int NUM_PTR = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [WORD_W-1:0]  instrWord,
  output ctrl_strobe_t       ctrl,
  output logic               retReq,
  output logic               illegal
);

  logic [7:0]       opc;
  logic             pendValid, nextPendValid;
  logic [SEL_W-1:0] pendSel, nextPendSel;
  logic [NIB_W-1:0] pendHi, nextPendHi;
  logic             isRet, isIllegal;

  assign opc = instrWord[WORD_W-1:WORD_W-8];

  always_comb begin
    ctrl          = '0;
    ctrl.aluOp    = ALU_PASS;
    isRet         = 1'b0;
    isIllegal     = 1'b0;
    nextPendValid = pendValid;
    nextPendSel   = pendSel;
    nextPendHi    = pendHi;
    if (instrValid) begin
      nextPendValid = 1'b0;
      unique case (opc)
        OPC_ADD: begin ctrl.aluOp = ALU_ADD; ctrl.wrWreg = 1'b1; ctrl.wrArith = 1'b1; end
        OPC_SUB: begin ctrl.aluOp = ALU_SUB; ctrl.wrWreg = 1'b1; ctrl.wrArith = 1'b1; end
        OPC_AND: begin ctrl.aluOp = ALU_AND; ctrl.wrWreg = 1'b1; ctrl.wrLogic = 1'b1; end
        OPC_IOR: begin ctrl.aluOp = ALU_IOR; ctrl.wrWreg = 1'b1; ctrl.wrLogic = 1'b1; end
        OPC_XOR: begin ctrl.aluOp = ALU_XOR; ctrl.wrWreg = 1'b1; ctrl.wrLogic = 1'b1; end
        OPC_MOV: ctrl.wrWreg = 1'b1;
        OPC_MUL: ctrl.wrProd = 1'b1;
        OPC_RET: begin ctrl.wrWreg = 1'b1; isRet = 1'b1; end
        OPC_BANK: begin
          if (instrWord[7:4] == 4'h0) ctrl.wrBank = 1'b1;
          else                        isIllegal   = 1'b1;
        end
        OPC_PTR1: begin
          if (instrWord[7:6] == 2'b00 && int'(instrWord[5:4]) < NUM_PTR) begin
            nextPendValid = 1'b1;
            nextPendSel   = instrWord[5:4];
            nextPendHi    = instrWord[3:0];
          end else begin
            isIllegal = 1'b1;
          end
        end
        OPC_PTR2: begin
          // orphan second word is a quiet no-operation
          if (pendValid) begin
            ctrl.wrPtr  = 1'b1;
            ctrl.ptrSel = pendSel;
            ctrl.ptrHi  = pendHi;
          end
        end
        default: isIllegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSel   <= '0;
      pendHi    <= '0;
      retReq    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      pendValid <= nextPendValid;
      pendSel   <= nextPendSel;
      pendHi    <= nextPendHi;
      retReq    <= isRet;
      illegal   <= isIllegal;
    end
  end

  // R11
  ret_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(retReq && illegal));

  // R10
  illegal_drops_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !pendValid);

  // R8
  ptr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opc == OPC_PTR2 && !pendValid) |=> (!illegal && !pendValid));

endmodule

// File: rtl/literal_exec_dp.sv
module literal_exec_dp
  import literal_exec_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 12
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              ctrl,
  input  logic [DATA_W-1:0]         lit,
  output logic [DATA_W-1:0]         wreg,
  output logic [DATA_W-1:0]         prodHi,
  output logic [DATA_W-1:0]         prodLo,
  output logic [BANK_W-1:0]         bankSel,
  output logic [NUM_PTR*PTR_W-1:0]  ptrFlat,
  output logic                      flagC,
  output logic                      flagDc,
  output logic                      flagZ,
  output logic                      flagOv,
  output logic                      flagN
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] aluRes;
  logic              aluC, aluDc, aluOv;
  logic [PROD_W-1:0] product;

  literal_exec_alu u_alu (
    .aluOp     (ctrl.aluOp),
    .opW       (wreg),
    .opK       (lit),
    .result    (aluRes),
    .carry     (aluC),
    .halfCarry (aluDc),
    .ovf       (aluOv)
  );

  assign product = {{DATA_W{1'b0}}, wreg} * {{DATA_W{1'b0}}, lit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wreg   <= '0;
      flagC  <= 1'b0;
      flagDc <= 1'b0;
      flagZ  <= 1'b0;
      flagOv <= 1'b0;
      flagN  <= 1'b0;
    end else begin
      if (ctrl.wrWreg) wreg <= aluRes;
      if (ctrl.wrArith) begin
        flagC  <= aluC;
        flagDc <= aluDc;
        flagOv <= aluOv;
      end
      if (ctrl.wrArith || ctrl.wrLogic) begin
        flagZ <= (aluRes == '0);
        flagN <= aluRes[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodHi <= '0;
      prodLo <= '0;
    end else if (ctrl.wrProd) begin
      prodHi <= product[PROD_W-1:DATA_W];
      prodLo <= product[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bankSel <= '0;
    else if (ctrl.wrBank) bankSel <= lit[BANK_W-1:0];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_ptr
      logic [PTR_W-1:0] ptrReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          ptrReg <= '0;
        else if (ctrl.wrPtr && int'(ctrl.ptrSel) == g)
          ptrReg <= PTR_W'({ctrl.ptrHi, lit});
      end
      assign ptrFlat[g*PTR_W +: PTR_W] = ptrReg;
    end
  endgenerate

  // R4
  zn_track_wreg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrArith || ctrl.wrLogic) |=> (flagZ == (wreg == '0)) && (flagN == wreg[DATA_W-1]));

  // R6
  mul_keeps_wreg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrProd |=> $stable(wreg) && $stable({flagC, flagDc, flagZ, flagOv, flagN}));

  // R7
  bank_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrBank |=> $stable(wreg) && $stable({prodHi, prodLo}) && $stable(ptrFlat));

endmodule

// File: rtl/literal_exec.sv
module literal_exec
  import literal_exec_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 12
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instrValid,
  input  logic [15:0]               instrWord,
  output logic [7:0]                wreg,
  output logic [7:0]                prodHi,
  output logic [7:0]                prodLo,
  output logic [3:0]                bankSel,
  output logic [NUM_PTR*PTR_W-1:0]  ptrFlat,
  output logic                      flagC,
  output logic                      flagDc,
  output logic                      flagZ,
  output logic                      flagOv,
  output logic                      flagN,
  output logic                      retReq,
  output logic                      illegal
);

  ctrl_strobe_t ctrl;

  literal_exec_ctrl #(.NUM_PTR(NUM_PTR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctrl       (ctrl),
    .retReq     (retReq),
    .illegal    (illegal)
  );

  literal_exec_dp #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .lit     (instrWord[DATA_W-1:0]),
    .wreg    (wreg),
    .prodHi  (prodHi),
    .prodLo  (prodLo),
    .bankSel (bankSel),
    .ptrFlat (ptrFlat),
    .flagC   (flagC),
    .flagDc  (flagDc),
    .flagZ   (flagZ),
    .flagOv  (flagOv),
    .flagN   (flagN)
  );

  // R12
  illegal_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(wreg) && $stable(bankSel) && $stable(ptrFlat) &&
                $stable({prodHi, prodLo}) && $stable({flagC, flagDc, flagZ, flagOv, flagN}));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(wreg) && $stable(bankSel) && $stable(ptrFlat) &&
                    $stable({prodHi, prodLo}) && !retReq && !illegal);

endmodule

// File: tb/literal_exec_tb.sv
`timescale 1ns/100ps
module literal_exec_tb;

  localparam int NUM_PTR = 3;
  localparam int PTR_W   = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid;
  logic [15:0] instrWord;
  logic [7:0]  wreg, prodHi, prodLo;
  logic [3:0]  bankSel;
  logic [NUM_PTR*PTR_W-1:0] ptrFlat;
  logic flagC, flagDc, flagZ, flagOv, flagN, retReq, illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0]  mW, mPH, mPL;
  logic [3:0]  mBank;
  logic [11:0] mPtr [3];
  logic mC, mDc, mZ, mOv, mN, eRet, eIll;
  logic       pendV;
  logic [1:0] pendS;
  logic [3:0] pendH;

  always #2.5 clk = ~clk;

  literal_exec #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wreg(wreg), .prodHi(prodHi), .prodLo(prodLo), .bankSel(bankSel), .ptrFlat(ptrFlat),
    .flagC(flagC), .flagDc(flagDc), .flagZ(flagZ), .flagOv(flagOv), .flagN(flagN),
    .retReq(retReq), .illegal(illegal)
  );

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  task automatic check(input string req);
    logic [70:0] got, exp;
    got = {wreg, prodHi, prodLo, bankSel, ptrFlat, flagC, flagDc, flagZ, flagOv, flagN, retReq, illegal};
    exp = {mW, mPH, mPL, mBank, mPtr[2], mPtr[1], mPtr[0], mC, mDc, mZ, mOv, mN, eRet, eIll};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: word=%h actual=%h expected=%h", req, instrWord, got, exp);
    end
  endtask

  task automatic setZN(input logic [7:0] r);
    mZ = (r == 8'h00);
    mN = r[7];
  endtask

  task automatic apply(input logic [15:0] w, input string req);
    logic [7:0] k, opc;
    int a, kk, s;
    logic [15:0] p;
    k = w[7:0]; opc = w[15:8];
    a = int'(mW); kk = int'(k);
    eRet = 1'b0; eIll = 1'b0;
    if (opc == 8'hF0) begin
      if (pendV) mPtr[pendS] = {pendH, k};
      pendV = 1'b0;
    end else begin
      pendV = 1'b0;
      case (opc)
        8'h0F: begin
          s = a + kk; mC = (s > 255); mDc = ((a % 16) + (kk % 16)) > 15;
          s = sgn(mW) + sgn(k); mOv = (s > 127) || (s < -128);
          mW = 8'(a + kk); setZN(mW);
        end
        8'h08: begin
          mC = (kk >= a); mDc = ((kk % 16) >= (a % 16));
          s = sgn(k) - sgn(mW); mOv = (s > 127) || (s < -128);
          mW = 8'(kk - a); setZN(mW);
        end
        8'h0B: begin mW = mW & k; setZN(mW); end
        8'h09: begin mW = mW | k; setZN(mW); end
        8'h0A: begin mW = mW ^ k; setZN(mW); end
        8'h0E: mW = k;
        8'h0D: begin p = 16'(a * kk); mPH = p[15:8]; mPL = p[7:0]; end
        8'h0C: begin mW = k; eRet = 1'b1; end
        8'h01: if (k[7:4] == 4'h0) mBank = k[3:0]; else eIll = 1'b1;
        8'hEE: if (k[7:6] == 2'b00 && k[5:4] != 2'b11) begin
                 pendV = 1'b1; pendS = k[5:4]; pendH = k[3:0];
               end else eIll = 1'b1;
        default: eIll = 1'b1;
      endcase
    end
    instrValid = 1'b1;
    instrWord  = w;
    @(negedge clk);
    check(req);
  endtask

  task automatic idle(input string req);
    eRet = 1'b0; eIll = 1'b0;
    instrValid = 1'b0;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] badWords [9];
    rstN = 1'b0; instrValid = 1'b0; instrWord = 16'h0000;
    mW = 0; mPH = 0; mPL = 0; mBank = 0; mPtr[0] = 0; mPtr[1] = 0; mPtr[2] = 0;
    mC = 0; mDc = 0; mZ = 0; mOv = 0; mN = 0; eRet = 0; eIll = 0;
    pendV = 0; pendS = 0; pendH = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R2 / R3 sweep: every W against literals incl. carry and sign boundaries
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 256; k++) begin
        if ((k % 5) == 0 || k == 15 || k == 16 || k == 127 || k == 128 || k == 1) begin
          apply({8'h0E, 8'(a)}, "R5 move");
          apply({8'h0F, 8'(k)}, "R2 add");
          apply({8'h0E, 8'(a)}, "R5 move");
          apply({8'h08, 8'(k)}, "R3 sub");
        end
      end
    end

    // R4 logic ops, flags C/DC/OV left from a prior add
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 256; k += 17) begin
        apply({8'h0E, 8'(a)}, "R5 move");
        apply({8'h0B, 8'(k)}, "R4 and");
        apply({8'h0E, 8'(a)}, "R5 move");
        apply({8'h09, 8'(k)}, "R4 ior");
        apply({8'h0E, 8'(a)}, "R5 move");
        apply({8'h0A, 8'(k)}, "R4 xor");
      end
      if (a % 32 == 0) apply(16'h0FFF, "R2 add sets carry");
    end

    // R6 multiply
    for (int a = 0; a < 256; a++) begin
      apply({8'h0E, 8'(a)}, "R5 move");
      for (int k = 0; k < 256; k += 3) apply({8'h0D, 8'(k)}, "R6 mul");
      apply(16'h0DFF, "R6 mul max");
    end

    // R7 bank
    for (int n = 0; n < 16; n++) apply({12'h010, 4'(n)}, "R7 bank");

    // R8 pointer loads, with and without idle gap
    for (int f = 0; f < 3; f++) begin
      for (int h = 0; h < 16; h += 5) begin
        apply({8'hEE, 2'b00, 2'(f), 4'(h)}, "R8 first word");
        apply({8'hF0, 8'(h * 16 + f + 3)}, "R8 second word");
        apply({8'hEE, 2'b00, 2'(f), 4'(15 - h)}, "R8 first word");
        idle("R8 gap");
        idle("R13 idle");
        apply({8'hF0, 8'(255 - h)}, "R8 second after gap");
      end
    end

    // R9 orphan second word
    apply(16'hF0A5, "R9 orphan");
    apply(16'hF05A, "R9 orphan again");

    // R10 abandoned and replaced first words
    apply(16'hEE1A, "R10 first");
    apply(16'h0E33, "R10 abandon runs move");
    apply(16'hF044, "R10 abandoned second is nop");
    apply(16'hEE05, "R10 first");
    apply(16'hEE27, "R10 replace");
    apply(16'hF011, "R10 replaced target");
    apply(16'hEE0C, "R10 first");
    apply(16'h0011, "R10 illegal drops pending");
    apply(16'hF099, "R10 after illegal nop");

    // R11 return with literal
    apply(16'h0FF0, "R2 setup flags");
    apply(16'h0C5A, "R11 return");
    idle("R11 pulse ends");
    apply(16'h0C00, "R11 return zero");
    apply(16'h0C81, "R11 back to back");
    idle("R11 pulse ends");

    // R12 malformed words
    badWords[0] = 16'h0000; badWords[1] = 16'h0500; badWords[2] = 16'h0011;
    badWords[3] = 16'hEE30; badWords[4] = 16'hEE85; badWords[5] = 16'hF155;
    badWords[6] = 16'hFFFF; badWords[7] = 16'h10AA; badWords[8] = 16'h01F3;
    for (int i = 0; i < 9; i++) apply(badWords[i], "R12 illegal");
    idle("R13 idle after illegal");

    // R13 idle with junk word on the bus
    instrWord = 16'h0F77;
    eRet = 1'b0; eIll = 1'b0; instrValid = 1'b0;
    @(negedge clk);
    check("R13 ignored word");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule